// File: doc/BRIEF.md
# Numerically Controlled Oscillator Phase Core

This block is the phase engine of a direct digital synthesizer. On every master clock it adds a frequency tuning word to a wide phase accumulator. It then takes the upper bits of that accumulator and adds a phase offset to them. The result is a short phase word that an external sine table and DAC turn into a waveform. The output frequency is the tuning word times the clock rate divided by 2^ACC_W. One offset LSB is a phase step of 2π/2^PH_W.

The core holds a bank of tuning words and a bank of phase offsets, both supplied on input buses. A frequency select and a phase select choose the active entries, so frequency-shift and phase-shift keying need nothing more than toggling a select line. A small command port sets three run-control flags:
- sleep freezes the accumulator and the output;
- zero holds the accumulator at zero;
- clear forces both selects to entry 0.

After power-up all three flags are set. A run command drops them all, and a halt command sets the zero flag.

Top module: `nco_core`

## Requirements
- R1: While the async reset is low and after it is released, `phase_o` is 0 and `valid_o` is 0. The flags start with sleep, zero and clear all set, so the outputs stay at 0 until a command releases them.
- R2: On each running edge (zero and sleep both clear), the accumulator grows by the selected tuning word modulo 2^ACC_W, and `valid_o` becomes 1. The new `phase_o` is the top PH_W bits of the accumulator as it was before that edge, plus the selected offset, modulo 2^PH_W.
- R3: `fsel_i` = k selects tuning word k, which is bits [k*ACC_W +: ACC_W] of `ftw_i`. `psel_i` = k selects offset k, which is bits [k*PH_W +: PH_W] of `ofs_i`. A select change is used at the next edge.
- R4: A selected tuning word above 2^(ACC_W-1) is replaced by 2^(ACC_W-1), so the output never exceeds half the clock rate.
- R5: While the zero flag is set, each edge sets the accumulator and `phase_o` to 0 and `valid_o` to 0.
- R6: While sleep is set and zero is clear, the accumulator and `phase_o` keep their values and `valid_o` is 0. After sleep is cleared, accumulation continues from the held value.
- R7: While the clear flag is set, both selects are treated as 0, whatever `fsel_i` and `psel_i` are.
- R8: Command op 1 (run) clears sleep, zero and clear. Command op 2 (halt) sets zero.
- R9: Command op 0 (load) copies `cmd_sleep_i`, `cmd_reset_i` and `cmd_clear_i` into the three flags. Op 3, and any cycle with `cmd_valid_i` low, leaves the flags unchanged.
- R10: A command accepted at edge k changes the flags at edge k. The datapath first acts on the new flags at edge k+1.
- R11: When sleep and zero are both set, zero wins: the accumulator is set to 0 rather than held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ftw_i | input | NFREQ*ACC_W | Packed tuning-word bank |
| ofs_i | input | NPHASE*PH_W | Packed phase-offset bank |
| fsel_i | input | $clog2(NFREQ) | Tuning-word select |
| psel_i | input | $clog2(NPHASE) | Phase-offset select |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 load, 1 run, 2 halt, 3 no-op |
| cmd_sleep_i | input | 1 | Sleep value for a load command |
| cmd_reset_i | input | 1 | Zero-flag value for a load command |
| cmd_clear_i | input | 1 | Clear value for a load command |
| phase_o | output | PH_W | Phase word for the sine lookup |
| valid_o | output | 1 | High when `phase_o` was produced by a running edge |

## Verification
A corrupted accumulator bit shows up as a wrong `phase_o` no later than the next running edge, provided the bit is among the top PH_W bits. A fault in the lower bits carries upward and shows within a few edges once the tuning words fill the low bits. A corrupted flag shows up one edge after the command that set it, either as `valid_o` out of step or as a phase that keeps moving when it should hold or reset. A select or clamp fault makes the per-cycle phase step differ from the arithmetic value the bench expects on the first running edge that uses the bad entry.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0,
    CMD_RUN  = 2'd1,
    CMD_HALT = 2'd2,
    CMD_NOP  = 2'd3
  } nco_cmd_e;

  typedef struct packed {
    logic sleep;
    logic zero;
    logic clr;
  } nco_ctl_t;

  localparam nco_ctl_t CTL_POWERUP = '{sleep: 1'b1, zero: 1'b1, clr: 1'b1};

endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  nco_ctl_t   cmd_word_i,
  output nco_ctl_t   ctl_o
);

  nco_ctl_t ctl_q;
  nco_ctl_t ctl_d;
  logic     ctl_en;

  assign ctl_en = cmd_valid_i && (cmd_op_i != CMD_NOP);

  always_comb begin
    ctl_d = ctl_q;
    case (nco_cmd_e'(cmd_op_i))
      CMD_LOAD: ctl_d = cmd_word_i;
      CMD_RUN:  ctl_d = '0;
      CMD_HALT: ctl_d.zero = 1'b1;
      default:  ctl_d = ctl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_POWERUP;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == CMD_RUN) |=> (ctl_q == '0)); // R8
  AST_HALT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == CMD_HALT) |=> ctl_q.zero); // R8
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid_i || cmd_op_i == CMD_NOP) |=> $stable(ctl_q)); // R9

endmodule

// File: rtl/nco_sel.sv
module nco_sel #(
  parameter int ACC_W    = 32,
  parameter int PH_W     = 12,
  parameter int NFREQ    = 2,
  parameter int NPHASE   = 4,
  parameter bit CLAMP_EN = 1'b1,
  localparam int FSEL_W  = $clog2(NFREQ),
  localparam int PSEL_W  = $clog2(NPHASE)
) (
  input  logic [NFREQ*ACC_W-1:0] ftw_i,
  input  logic [NPHASE*PH_W-1:0] ofs_i,
  input  logic [FSEL_W-1:0]      fsel_i,
  input  logic [PSEL_W-1:0]      psel_i,
  input  logic                   clr_i,
  output logic [ACC_W-1:0]       ftw_o,
  output logic [PH_W-1:0]        ofs_o
);

  localparam logic [ACC_W-1:0] FTW_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0]  ftw_arr [NFREQ];
  logic [PH_W-1:0]   ofs_arr [NPHASE];
  logic [FSEL_W-1:0] fsel_eff;
  logic [PSEL_W-1:0] psel_eff;
  logic [ACC_W-1:0]  ftw_raw;

  for (genvar g = 0; g < NFREQ; g++) begin : g_ftw
    assign ftw_arr[g] = ftw_i[g*ACC_W +: ACC_W];
  end

  for (genvar g = 0; g < NPHASE; g++) begin : g_ofs
    assign ofs_arr[g] = ofs_i[g*PH_W +: PH_W];
  end

  assign fsel_eff = clr_i ? '0 : fsel_i;
  assign psel_eff = clr_i ? '0 : psel_i;
  assign ftw_raw  = ftw_arr[fsel_eff];
  assign ofs_o    = ofs_arr[psel_eff];

  if (CLAMP_EN) begin : g_clamp
    assign ftw_o = (ftw_raw > FTW_MAX) ? FTW_MAX : ftw_raw;
  end else begin : g_pass
    assign ftw_o = ftw_raw;
  end

endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  nco_ctl_t         ctl_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PH_W-1:0]  ofs_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             valid_o
);

  localparam logic [ACC_W-1:0] STEP_MAX = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             val_q, val_d;
  logic             upd_en;

  assign upd_en = ctl_i.zero || !ctl_i.sleep;

  always_comb begin
    acc_d = acc_q;
    ph_d  = ph_q;
    val_d = 1'b0;
    if (ctl_i.zero) begin
      acc_d = '0;
      ph_d  = '0;
    end else if (!ctl_i.sleep) begin
      acc_d = acc_q + ftw_i;
      ph_d  = acc_q[ACC_W-1 -: PH_W] + ofs_i;
      val_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= '0;
      val_q <= 1'b0;
    end else begin
      if (upd_en) begin
        acc_q <= acc_d;
        ph_q  <= ph_d;
      end
      val_q <= val_d;
    end
  end

  assign phase_o = ph_q;
  assign valid_o = val_q;

  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.zero |=> (phase_o == '0 && !valid_o)); // R5
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.sleep && !ctl_i.zero) |=> ($stable(ph_q) && $stable(acc_q) && !valid_o)); // R6
  AST_RUN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.zero && !ctl_i.sleep) |=> valid_o); // R2
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.zero && !ctl_i.sleep) |=> ((acc_q - $past(acc_q)) <= STEP_MAX)); // R4

endmodule

// File: rtl/nco_core.sv
module nco_core
  import nco_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int PH_W     = 12,
  parameter int NFREQ    = 2,
  parameter int NPHASE   = 4,
  parameter bit CLAMP_EN = 1'b1,
  localparam int FSEL_W  = $clog2(NFREQ),
  localparam int PSEL_W  = $clog2(NPHASE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NFREQ*ACC_W-1:0] ftw_i,
  input  logic [NPHASE*PH_W-1:0] ofs_i,
  input  logic [FSEL_W-1:0]      fsel_i,
  input  logic [PSEL_W-1:0]      psel_i,
  input  logic                   cmd_valid_i,
  input  logic [1:0]             cmd_op_i,
  input  logic                   cmd_sleep_i,
  input  logic                   cmd_reset_i,
  input  logic                   cmd_clear_i,
  output logic [PH_W-1:0]        phase_o,
  output logic                   valid_o
);

  logic             rst_int_n;
  nco_ctl_t         cmd_word;
  nco_ctl_t         ctl;
  logic [ACC_W-1:0] ftw_sel;
  logic [PH_W-1:0]  ofs_sel;

  assign cmd_word = '{sleep: cmd_sleep_i, zero: cmd_reset_i, clr: cmd_clear_i};

  nco_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  nco_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_word_i  (cmd_word),
    .ctl_o       (ctl)
  );

  nco_sel #(
    .ACC_W    (ACC_W),
    .PH_W     (PH_W),
    .NFREQ    (NFREQ),
    .NPHASE   (NPHASE),
    .CLAMP_EN (CLAMP_EN)
  ) u_sel (
    .ftw_i  (ftw_i),
    .ofs_i  (ofs_i),
    .fsel_i (fsel_i),
    .psel_i (psel_i),
    .clr_i  (ctl.clr),
    .ftw_o  (ftw_sel),
    .ofs_o  (ofs_sel)
  );

  nco_accum #(
    .ACC_W (ACC_W),
    .PH_W  (PH_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctl_i   (ctl),
    .ftw_i   (ftw_sel),
    .ofs_i   (ofs_sel),
    .phase_o (phase_o),
    .valid_o (valid_o)
  );

endmodule

// File: tb/nco_core_bench.sv
`timescale 1ns/1ps
module nco_core_bench;

  localparam int ACC_W  = 16;
  localparam int PH_W   = 6;
  localparam int NFREQ  = 2;
  localparam int NPHASE = 4;
  localparam logic [ACC_W-1:0] HALF = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ACC_W-1:0] tb_ftw [NFREQ];
  logic [PH_W-1:0]  tb_ofs [NPHASE];
  logic fsel = 1'b0;
  logic [1:0] psel = 2'd0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic c_sleep = 1'b0, c_rst = 1'b0, c_clr = 1'b0;
  logic [PH_W-1:0] phase_o;
  logic valid_o;

  logic [ACC_W-1:0] m_acc = '0;
  logic [PH_W-1:0]  m_ph = '0;
  logic m_val = 1'b0;
  logic m_sleep = 1'b1, m_zero = 1'b1, m_clr = 1'b1;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nco_core #(.ACC_W(ACC_W), .PH_W(PH_W), .NFREQ(NFREQ), .NPHASE(NPHASE)) u_nco_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .ftw_i       ({tb_ftw[1], tb_ftw[0]}),
    .ofs_i       ({tb_ofs[3], tb_ofs[2], tb_ofs[1], tb_ofs[0]}),
    .fsel_i      (fsel),
    .psel_i      (psel),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_sleep_i (c_sleep),
    .cmd_reset_i (c_rst),
    .cmd_clear_i (c_clr),
    .phase_o     (phase_o),
    .valid_o     (valid_o)
  );

  task automatic model_step();
    logic [ACC_W-1:0] f;
    int fs, ps;
    if (m_zero) begin
      m_acc = '0; m_ph = '0; m_val = 1'b0;
    end else if (m_sleep) begin
      m_val = 1'b0;
    end else begin
      fs = m_clr ? 0 : int'(fsel);
      ps = m_clr ? 0 : int'(psel);
      f = tb_ftw[fs];
      if (f > HALF) f = HALF;
      m_ph = m_acc[ACC_W-1 -: PH_W] + tb_ofs[ps];
      m_acc = m_acc + f;
      m_val = 1'b1;
    end
    if (cmd_valid) begin
      case (cmd_op)
        2'd0: begin m_sleep = c_sleep; m_zero = c_rst; m_clr = c_clr; end
        2'd1: begin m_sleep = 1'b0; m_zero = 1'b0; m_clr = 1'b0; end
        2'd2: m_zero = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag);
    nchk++;
    if (phase_o !== m_ph || valid_o !== m_val) begin
      nbad++;
      $display("FAIL %s: phase=%0d valid=%0b expected phase=%0d valid=%0b",
               tag, phase_o, valid_o, m_ph, m_val);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag);
  endtask

  task automatic cmd(input logic [1:0] op, input logic s, input logic r, input logic c,
                     input string tag);
    cmd_valid = 1'b1; cmd_op = op; c_sleep = s; c_rst = r; c_clr = c;
    cyc(tag);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NFREQ; i++) tb_ftw[i] = '0;
    for (int i = 0; i < NPHASE; i++) tb_ofs[i] = '0;
    // R1: reset state, during and after release
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    tb_ftw[0] = 16'd700; tb_ofs[0] = 6'd5;
    for (int i = 0; i < 6; i++) cyc("R1");

    // R8 / R10: run command; datapath reacts one edge later
    cmd(2'd1, 1'b0, 1'b0, 1'b0, "R10");
    cyc("R10");
    cyc("R8");

    // R2: offset sweep over all codes with a step of one top-bit LSB
    tb_ftw[0] = 16'd1024; fsel = 1'b0; psel = 2'd0;
    for (int o = 0; o < (1 << PH_W); o++) begin
      tb_ofs[0] = o[PH_W-1:0];
      cyc("R2");
    end

    // R3: every select combination with arbitrary words
    for (int f = 0; f < NFREQ; f++) begin
      for (int p = 0; p < NPHASE; p++) begin
        for (int i = 0; i < NFREQ; i++) tb_ftw[i] = 16'($urandom_range(0, 32768));
        for (int i = 0; i < NPHASE; i++) tb_ofs[i] = 6'($urandom);
        fsel = f[0]; psel = p[1:0];
        for (int k = 0; k < 6; k++) cyc("R3");
      end
    end

    // R4: words above half scale are clamped
    fsel = 1'b1;
    tb_ftw[1] = 16'h8001;
    for (int k = 0; k < 4; k++) cyc("R4");
    tb_ftw[1] = 16'hFFFF;
    for (int k = 0; k < 4; k++) cyc("R4");
    tb_ftw[1] = HALF;
    for (int k = 0; k < 3; k++) cyc("R4");

    // R6: sleep holds, then resumes from the held value
    tb_ftw[1] = 16'd3333;
    cmd(2'd0, 1'b1, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 5; k++) cyc("R6");
    cmd(2'd0, 1'b0, 1'b0, 1'b0, "R6");
    for (int k = 0; k < 4; k++) cyc("R6");

    // R7: clear forces entry 0 for both selects
    tb_ftw[0] = 16'd900; tb_ftw[1] = 16'd5000;
    tb_ofs[0] = 6'd1; tb_ofs[3] = 6'd40;
    fsel = 1'b1; psel = 2'd3;
    cmd(2'd0, 1'b0, 1'b0, 1'b1, "R7");
    for (int k = 0; k < 6; k++) cyc("R7");

    // R5 / R8: halt sets the zero flag
    cmd(2'd2, 1'b0, 1'b0, 1'b0, "R5");
    for (int k = 0; k < 4; k++) cyc("R5");

    // R11: zero wins over sleep, then restart from zero
    cmd(2'd1, 1'b0, 1'b0, 1'b0, "R11");
    for (int k = 0; k < 3; k++) cyc("R11");
    cmd(2'd0, 1'b1, 1'b1, 1'b0, "R11");
    for (int k = 0; k < 3; k++) cyc("R11");
    cmd(2'd0, 1'b0, 1'b0, 1'b0, "R11");
    for (int k = 0; k < 4; k++) cyc("R11");

    // R9: no-op and unstrobed commands leave flags alone
    cmd(2'd3, 1'b1, 1'b1, 1'b1, "R9");
    for (int k = 0; k < 3; k++) cyc("R9");
    cmd_valid = 1'b0; cmd_op = 2'd2; c_sleep = 1'b1; c_rst = 1'b1;
    for (int k = 0; k < 3; k++) cyc("R9");
    cmd_op = 2'd3;
    cmd(2'd0, 1'b1, 1'b0, 1'b0, "R9");
    for (int k = 0; k < 3; k++) cyc("R9");

    finish_run();
  end

endmodule